// File: doc/BRIEF.md
# DDS Channel Register Update Sequencer

This block programs a single output channel of a four-channel direct digital synthesizer. A request names a channel, one of three per-channel registers (frequency tuning word, phase offset word or amplitude control) and a value. The block drives a fixed transaction sequence on a byte-level register port. It first reads the channel-select byte. It then rewrites that byte so that only the target channel is enabled, and writes the formatted data register. Next it raises an update strobe that is wide enough to be caught by the synthesizer's slow sync clock. Last, it writes the saved channel-select byte back.

The register port below the block carries one transaction at a time. Each transaction is an address, a read/write direction, a byte count and up to four data bytes, and the port answers with a one-cycle acknowledge. The serial wire protocol and the synthesizer core sit outside this block. Requests that arrive while a sequence is running are dropped. Malformed requests raise a one-cycle error and cause no port traffic.

Top module: `dds_chan_seq`

## Requirements
- R1: After reset, busy, done, err, upd_strobe and rp_valid are all low.
- R2: The first port transaction of an accepted request is a 1-byte read at address 0x80, which is the channel-select address 0x00 with the read flag bit 7 set.
- R3: The second transaction is a 1-byte write to address 0x00. Its bits 3..0 equal the byte that was read. Of bits 7..4, only bit 4+channel is set.
- R4: The third transaction writes the data register selected by the request code. Code 0 writes 4 bytes to 0x04 with the 32-bit value. Code 1 writes 2 bytes to 0x05 with value[13:0] and the top two bits zero. Code 2 writes 3 bytes to 0x06 as {0x00, middle, value[7:0]}, where the middle byte holds value[9:8] in bits 1..0. The last byte of every write is carried in rp_wdata[7:0].
- R5: For code 2, bit 4 of the middle byte (multiplier enable) is set exactly when value[9:0] differs from the full-scale code 0x3FF.
- R6: After the data write is acknowledged, upd_strobe goes high for exactly 4×STROBE_PERIODS clock cycles (20 by default). It is never high while rp_valid is high.
- R7: After upd_strobe falls, the fourth transaction is a 1-byte write of the saved byte to address 0x00. No strobe follows it.
- R8: busy is high from the cycle after a request is accepted until the sequence ends. At the end, done pulses high for one cycle with busy low.
- R9: A request presented while busy is ignored, so one sequence makes exactly four port transactions and produces one done pulse.
- R10: A request with a channel number above 3 or with code 3 produces a one-cycle err pulse. It causes no port transaction and leaves busy low.
- R11: Every port write uses an address with bit 7 clear, and every port read uses an address with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_chan | input | 3 | Target channel number |
| req_reg | input | 2 | Register code: 0 frequency, 1 phase, 2 amplitude |
| req_value | input | 32 | Value for the target register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | One-cycle pulse for a rejected request |
| upd_strobe | output | 1 | Update strobe toward the synthesizer |
| rp_valid | output | 1 | Register port transaction request |
| rp_read | output | 1 | 1 for read, 0 for write |
| rp_addr | output | 8 | Register address, bit 7 set for reads |
| rp_len | output | 3 | Byte count of the transaction |
| rp_wdata | output | 32 | Write bytes, most significant first, last byte in bits 7..0 |
| rp_ack | input | 1 | One-cycle transaction acknowledge |
| rp_rdata | input | 8 | Read byte, valid with rp_ack |

## Verification
The bench replays random channels, codes, values and starting channel-select bytes against a port model whose acknowledge latency varies. It compares each of the four logged transactions against expected values that the bench computes. Directed cases cover:
- the full-scale amplitude code, where a wrong comparison would leave the multiplier enabled;
- a select byte whose low nibble must survive, which a design that rebuilt the byte from scratch would clear;
- a second request injected mid-sequence, which a design that re-accepted it would show as extra transactions;
- out-of-range channels and the unsupported code, which must produce no traffic at all.

The strobe width is counted cycle by cycle, so an off-by-one in the timer changes the count. A strobe that overlapped the restore write shows up as overlap.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;

    localparam logic [7:0] ADDR_CHSEL = 8'h00;
    localparam logic [7:0] ADDR_FREQ  = 8'h04;
    localparam logic [7:0] ADDR_PHASE = 8'h05;
    localparam logic [7:0] ADDR_AMPL  = 8'h06;
    localparam logic [7:0] RD_FLAG    = 8'h80;

    localparam logic [1:0] CODE_FREQ  = 2'd0;
    localparam logic [1:0] CODE_PHASE = 2'd1;
    localparam logic [1:0] CODE_AMPL  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SELECT,
        ST_DATA,
        ST_STROBE,
        ST_RESTORE
    } seq_state_e;

    function automatic logic code_supported(input logic [1:0] code);
        return (code == CODE_FREQ) || (code == CODE_PHASE) || (code == CODE_AMPL);
    endfunction

endpackage

// File: rtl/dds_payload_fmt.sv
module dds_payload_fmt
    import dds_seq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 3,
    parameter int PHASE_W  = 14,
    parameter int SCALE_W  = 10,
    parameter int MULT_BIT = 4
) (
    input  logic [1:0]        code,
    input  logic [DATA_W-1:0] value,
    output logic [7:0]        addr,
    output logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] data
);
    localparam logic [SCALE_W-1:0] FULL_SCALE = '1;

    logic [15:0] phase_word;
    logic [7:0]  amp_mid;
    logic        mult_en;

    always_comb begin
        phase_word = 16'(value[PHASE_W-1:0]);
        mult_en    = (value[SCALE_W-1:0] != FULL_SCALE);
        amp_mid    = 8'(value[SCALE_W-1:8]);
        amp_mid[MULT_BIT] = mult_en;
        unique case (code)
            CODE_FREQ: begin
                addr = ADDR_FREQ;
                len  = LEN_W'(4);
                data = value;
            end
            CODE_PHASE: begin
                addr = ADDR_PHASE;
                len  = LEN_W'(2);
                data = DATA_W'(phase_word);
            end
            default: begin
                addr = ADDR_AMPL;
                len  = LEN_W'(3);
                data = DATA_W'({8'h00, amp_mid, value[7:0]});
            end
        endcase
    end

    always_comb begin
        if (code == CODE_AMPL) begin
            assert_ampl_top_clear_R4: assert (data[DATA_W-1:16] == '0);
        end
    end

endmodule

// File: rtl/dds_chsel_mask.sv
module dds_chsel_mask #(
    parameter int NUM_CH = 4,
    parameter int CHAN_W = 3,
    parameter int EN_LSB = 4
) (
    input  logic [7:0]        saved,
    input  logic [CHAN_W-1:0] chan,
    output logic [7:0]        sel_byte
);
    for (genvar i = 0; i < 8; i++) begin : g_bit
        if (i >= EN_LSB && i < EN_LSB + NUM_CH) begin : g_en
            assign sel_byte[i] = (chan == CHAN_W'(i - EN_LSB));
        end else begin : g_keep
            assign sel_byte[i] = saved[i];
        end
    end

    always_comb begin
        assert_single_enable_R3: assert ($countones(sel_byte[EN_LSB +: NUM_CH]) <= 1);
    end

endmodule

// File: rtl/dds_strobe_timer.sv
module dds_strobe_timer #(
    parameter int SYNC_DIV       = 4,
    parameter int STROBE_PERIODS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic strobe,
    output logic finish
);
    localparam int CYCLES = SYNC_DIV * STROBE_PERIODS;
    localparam int CNT_W  = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.count = CNT_W'(CYCLES);
        end else if (r_q.count != '0) begin
            r_d.count = r_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign strobe = (r_q.count != '0);
    assign finish = (r_q.count == CNT_W'(1));

    logic [CNT_W-1:0] width_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      width_q <= '0;
        else if (strobe) width_q <= width_q + CNT_W'(1);
        else             width_q <= '0;
    end

    assert_width_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= CNT_W'(CYCLES));
    assert_width_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> (width_q == CNT_W'(CYCLES)));
    assert_finish_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> strobe);

endmodule

// File: rtl/dds_chan_seq.sv
module dds_chan_seq
    import dds_seq_pkg::*;
#(
    parameter int NUM_CH         = 4,
    parameter int CHAN_W         = 3,
    parameter int DATA_W         = 32,
    parameter int LEN_W          = 3,
    parameter int SYNC_DIV       = 4,
    parameter int STROBE_PERIODS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [1:0]        req_reg,
    input  logic [DATA_W-1:0] req_value,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              upd_strobe,
    output logic              rp_valid,
    output logic              rp_read,
    output logic [7:0]        rp_addr,
    output logic [LEN_W-1:0]  rp_len,
    output logic [DATA_W-1:0] rp_wdata,
    input  logic              rp_ack,
    input  logic [7:0]        rp_rdata
);
    localparam logic [CHAN_W-1:0] LAST_CH = CHAN_W'(NUM_CH - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [7:0]        saved;
        logic [CHAN_W-1:0] chan;
        logic [1:0]        code;
        logic [DATA_W-1:0] value;
        logic              done;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [7:0]        fmt_addr;
    logic [LEN_W-1:0]  fmt_len;
    logic [DATA_W-1:0] fmt_data;
    logic [7:0]        sel_byte;
    logic              tmr_start;
    logic              tmr_finish;

    dds_payload_fmt #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_fmt (
        .code  (r_q.code),
        .value (r_q.value),
        .addr  (fmt_addr),
        .len   (fmt_len),
        .data  (fmt_data)
    );

    dds_chsel_mask #(
        .NUM_CH (NUM_CH),
        .CHAN_W (CHAN_W)
    ) u_mask (
        .saved    (r_q.saved),
        .chan     (r_q.chan),
        .sel_byte (sel_byte)
    );

    dds_strobe_timer #(
        .SYNC_DIV       (SYNC_DIV),
        .STROBE_PERIODS (STROBE_PERIODS)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .strobe (upd_strobe),
        .finish (tmr_finish)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        tmr_start = 1'b0;
        rp_valid  = 1'b0;
        rp_read   = 1'b0;
        rp_addr   = ADDR_CHSEL;
        rp_len    = LEN_W'(1);
        rp_wdata  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_chan <= LAST_CH && code_supported(req_reg)) begin
                        r_d.state = ST_READ;
                        r_d.chan  = req_chan;
                        r_d.code  = req_reg;
                        r_d.value = req_value;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_READ: begin
                rp_valid = 1'b1;
                rp_read  = 1'b1;
                rp_addr  = ADDR_CHSEL | RD_FLAG;
                if (rp_ack) begin
                    r_d.saved = rp_rdata;
                    r_d.state = ST_SELECT;
                end
            end
            ST_SELECT: begin
                rp_valid = 1'b1;
                rp_wdata = DATA_W'(sel_byte);
                if (rp_ack) r_d.state = ST_DATA;
            end
            ST_DATA: begin
                rp_valid = 1'b1;
                rp_addr  = fmt_addr;
                rp_len   = fmt_len;
                rp_wdata = fmt_data;
                if (rp_ack) begin
                    tmr_start = 1'b1;
                    r_d.state = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (tmr_finish) r_d.state = ST_RESTORE;
            end
            ST_RESTORE: begin
                rp_valid = 1'b1;
                rp_wdata = DATA_W'(r_q.saved);
                if (rp_ack) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state != ST_IDLE);
    assign done = r_q.done;
    assign err  = r_q.err;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !err && !rp_valid));
    assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rp_valid && rp_read && rp_len == LEN_W'(1)));
    assert_no_strobe_on_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> !rp_valid);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err) ##1 !done);
    assert_busy_locks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.chan) && $stable(r_q.value)));
    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    assert_write_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_valid && !rp_read) |-> !rp_addr[7]);
    assert_read_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_valid && rp_read) |-> rp_addr[7]);

endmodule

// File: tb/tb_dds_chan_seq.sv
module tb_dds_chan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STROBE_LEN = 20;
    localparam int LOG_N      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic [1:0]  req_reg = '0;
    logic [31:0] req_value = '0;
    logic        busy, done, err, upd_strobe;
    logic        rp_valid, rp_read;
    logic [7:0]  rp_addr;
    logic [2:0]  rp_len;
    logic [31:0] rp_wdata;
    logic        rp_ack;
    logic [7:0]  rp_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dds_chan_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_reg(req_reg), .req_value(req_value), .busy(busy), .done(done),
        .err(err), .upd_strobe(upd_strobe), .rp_valid(rp_valid), .rp_read(rp_read),
        .rp_addr(rp_addr), .rp_len(rp_len), .rp_wdata(rp_wdata), .rp_ack(rp_ack),
        .rp_rdata(rp_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] csr_model = 8'h00;

    logic        lg_read [LOG_N];
    logic [7:0]  lg_addr [LOG_N];
    logic [2:0]  lg_len  [LOG_N];
    logic [31:0] lg_data [LOG_N];
    int          lg_strb [LOG_N];
    int log_n = 0;
    int wait_cnt = 0;
    int strobe_total = 0;
    int overlap = 0;
    int cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rp_ack   <= 1'b0;
            rp_rdata <= 8'h00;
            wait_cnt <= 0;
        end else begin
            rp_ack <= 1'b0;
            if (rp_valid && !rp_ack) begin
                if (wait_cnt >= (log_n % 4)) begin
                    rp_ack   <= 1'b1;
                    rp_rdata <= csr_model;
                    wait_cnt <= 0;
                    if (log_n < LOG_N) begin
                        lg_read[log_n] <= rp_read;
                        lg_addr[log_n] <= rp_addr;
                        lg_len[log_n]  <= rp_len;
                        lg_data[log_n] <= rp_wdata;
                        lg_strb[log_n] <= strobe_total;
                    end
                    log_n <= log_n + 1;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && upd_strobe) strobe_total <= strobe_total + 1;
        if (rst_n && upd_strobe && rp_valid) overlap <= overlap + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_addr(input logic [1:0] c);
        return (c == 2'd0) ? 8'h04 : (c == 2'd1) ? 8'h05 : 8'h06;
    endfunction

    function automatic logic [2:0] exp_len(input logic [1:0] c);
        return (c == 2'd0) ? 3'd4 : (c == 2'd1) ? 3'd2 : 3'd3;
    endfunction

    function automatic logic [31:0] exp_data(input logic [1:0] c, input logic [31:0] v);
        logic mult;
        mult = (v[9:0] != 10'h3FF);
        if (c == 2'd0) return v;
        if (c == 2'd1) return {18'h0, v[13:0]};
        return {8'h00, 8'h00, 3'b000, mult, 2'b00, v[9:8], v[7:0]};
    endfunction

    task automatic run_op(input logic [2:0] ch, input logic [1:0] rc, input logic [31:0] v,
                          input logic [7:0] csr, input bit inject);
        int base;
        int t;
        logic [7:0] sel;
        csr_model = csr;
        base = log_n;
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_reg = rc; req_value = v;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (inject) begin
            repeat (6) @(negedge clk);
            req_valid = 1'b1; req_chan = ch ^ 3'd1; req_reg = 2'd0; req_value = ~v;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R8 done pulse", done, 1);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(log_n - base == 4, "R9 four transactions", log_n - base, 4);
        if (log_n - base == 4) begin
            sel = (csr & 8'h0F) | (8'h10 << ch);
            chk(lg_read[base] && lg_addr[base] == 8'h80 && lg_len[base] == 3'd1,
                "R2 read chsel", {lg_read[base], lg_addr[base]}, 12'h180);
            chk(!lg_read[base+1] && lg_addr[base+1] == 8'h00 && lg_len[base+1] == 3'd1,
                "R3 select addr", lg_addr[base+1], 0);
            chk(lg_data[base+1][7:0] == sel, "R3 select byte", lg_data[base+1][7:0], sel);
            chk(!lg_read[base+2] && lg_addr[base+2] == exp_addr(rc) && lg_len[base+2] == exp_len(rc),
                "R4 data addr/len", {lg_addr[base+2], 1'b0, lg_len[base+2]},
                {exp_addr(rc), 1'b0, exp_len(rc)});
            chk(lg_data[base+2] == exp_data(rc, v), (rc == 2'd2) ? "R5 ampl data" : "R4 data word",
                lg_data[base+2], exp_data(rc, v));
            chk(lg_strb[base+3] - lg_strb[base+2] == STROBE_LEN, "R6 strobe width",
                lg_strb[base+3] - lg_strb[base+2], STROBE_LEN);
            chk(lg_strb[base+2] == lg_strb[base+1], "R6 no strobe before data",
                lg_strb[base+2] - lg_strb[base+1], 0);
            chk(!lg_read[base+3] && lg_addr[base+3] == 8'h00 && lg_data[base+3][7:0] == csr,
                "R7 restore", lg_data[base+3][7:0], csr);
            chk(strobe_total == lg_strb[base+3], "R7 no strobe after restore",
                strobe_total - lg_strb[base+3], 0);
            chk(!lg_read[base+1] && !lg_addr[base+2][7] && lg_read[base] && lg_addr[base][7],
                "R11 address flag", lg_addr[base+2], exp_addr(rc));
        end
    endtask

    task automatic bad_req(input logic [2:0] ch, input logic [1:0] rc);
        int base;
        base = log_n;
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_reg = rc; req_value = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1, "R10 err pulse", err, 1);
        chk(busy == 1'b0, "R10 stays idle", busy, 0);
        @(negedge clk);
        chk(err == 1'b0, "R10 err one cycle", err, 0);
        repeat (5) @(negedge clk);
        chk(log_n == base && !rp_valid, "R10 no traffic", log_n - base, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0D5));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !upd_strobe && !rp_valid, "R1 reset state",
            {busy, done, err, upd_strobe, rp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !upd_strobe && !rp_valid, "R1 idle after reset",
            {busy, upd_strobe, rp_valid}, 0);

        run_op(3'd0, 2'd0, 32'h1234_5678, 8'hF0, 1'b0);
        run_op(3'd3, 2'd1, 32'hFFFF_FFFF, 8'h5A, 1'b0);
        run_op(3'd2, 2'd2, 32'h0000_03FF, 8'h36, 1'b0);
        run_op(3'd1, 2'd2, 32'h0000_0155, 8'h0F, 1'b0);
        run_op(3'd2, 2'd0, 32'hCAFE_F00D, 8'hA5, 1'b1);
        bad_req(3'd4, 2'd0);
        bad_req(3'd7, 2'd1);
        bad_req(3'd1, 2'd3);

        for (int i = 0; i < 40; i++) begin
            logic [31:0] v;
            logic [1:0]  rc;
            v  = $urandom;
            rc = 2'($urandom_range(0, 2));
            if (i % 7 == 0) v[9:0] = 10'h3FF;
            run_op(3'($urandom_range(0, 3)), rc, v, 8'($urandom), (i % 5 == 0));
        end

        chk(overlap == 0, "R6 strobe vs port overlap", overlap, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule